// File: doc/BRIEF.md
# Software-Managed Address Translation Table

This block is a small, fully associative translation table that software fills and inspects through a set of staging values. Each of its entries maps an aligned pair of adjacent virtual pages, one even and one odd, onto two independent physical frames. Each frame carries its own valid, dirty and cache-attribute bits. An entry is tagged with a virtual page number, an 8-bit address-space identifier and a per-entry page-size mask. A global bit lets an entry match in every address space.

The processor presents the staging values and pulses `opValid` with one of four operation codes. The four operations are an indexed write, a write to the slot named by a free-running random index, a probe, and a read back of one entry. One clock later `doneO` pulses. In that same cycle the probe result appears on `idxO`, the read-back values appear on the staging outputs, and a flush request appears if the read loads a different address space. A separate combinational port translates a virtual address and identifier into a physical address.

Top module: `xlt_unit`

## Requirements
- R1: After reset every output register is zero (`doneO`, `flushReq`, `idxO`, `hiO`, `lo0O`, `lo1O`, `maskO`), and every entry is cleared with valid bits at 0, so no lookup reports `lkValid`.
- R2: The operation codes are 0 for an indexed write, 1 for a random write, 2 for a probe and 3 for a read. `doneO` is high for exactly the one cycle after each `opValid` cycle, and the results of that operation are visible in that same cycle.
- R3: A write stores the following fields. The tag is `stageHi[31:13]` and the identifier is `stageHi[7:0]`. The size mask is `stageMask[24:13]`. The global bit is `stageLo0[0] AND stageLo1[0]`. For each half, valid comes from bit 1, dirty from bit 2, the attribute from bits 5:3 and the frame number from bits 25:6 of its low word. An indexed write targets `stageIdx` modulo the entry count, and a random write targets `randIdx`.
- R4: On a probe hit, `idxO` becomes the number of the matching entry, with all higher bits clear. An entry matches when its tag equals `stageHi[31:13]` on every bit not set in its size mask, and its global bit is set or its identifier equals `stageHi[7:0]`.
- R5: When several entries match a probe, the lowest-numbered one is reported.
- R6: On a probe miss, `idxO` becomes `stageIdx` with bit 31 forced to 1.
- R7: A read of entry `stageIdx` modulo the count rebuilds the values from the stored fields. `hiO` carries the tag in bits 31:13, zeros in bits 12:8 and the identifier in bits 7:0. Each low word carries the frame number in bits 25:6, the attribute in bits 5:3, dirty in bit 2, valid in bit 1 and the global bit in bit 0. `maskO` holds the mask in bits 24:13.
- R8: A read of a non-global entry whose identifier differs from `stageHi[7:0]` raises `flushReq` for the one result cycle. Any other read leaves it low.
- R9: A lookup of (`lkVaddr`, `lkAsid`) uses the probe matching rule and picks the lowest matching entry. The lookup then works as follows:
  - The half is selected by the address bit just above the page offset.
  - `lkPaddr` is the frame address (frame number shifted left by 12) with the page-offset bits taken from `lkVaddr`.
  - `lkValid`, `lkDirty` and `lkAttr` come from the selected half.
  - `lkValid` is low whenever that half is not valid, even on a hit.
  - With no hit, all lookup outputs except `lkHit` are zero.
- R10: A size mask with k contiguous low ones (from bit 13) gives pages of 4 KiB shifted left by k. The odd half is then selected by address bit 12+k, and the tag is compared only on bits 13+k and up.
- R11: Writes and probes leave `hiO`, `lo0O`, `lo1O` and `maskO` unchanged. Writes and reads leave `idxO` unchanged. No output changes without an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opKind | input | 2 | Operation code (0 indexed write, 1 random write, 2 probe, 3 read) |
| stageHi | input | 32 | Staged virtual tag and identifier |
| stageLo0 | input | 32 | Staged even-page word |
| stageLo1 | input | 32 | Staged odd-page word |
| stageMask | input | 32 | Staged page-size mask (bits 24:13) |
| stageIdx | input | 32 | Staged entry index |
| randIdx | input | 4 | Random slot for random writes |
| lkVaddr | input | 32 | Lookup virtual address |
| lkAsid | input | 8 | Lookup address-space identifier |
| doneO | output | 1 | Operation complete pulse |
| idxO | output | 32 | Index result of the last probe |
| hiO | output | 32 | Read-back tag and identifier |
| lo0O | output | 32 | Read-back even-page word |
| lo1O | output | 32 | Read-back odd-page word |
| maskO | output | 32 | Read-back size mask |
| flushReq | output | 1 | Address-space change on read |
| lkHit | output | 1 | Lookup matched an entry |
| lkValid | output | 1 | Selected half is valid |
| lkPaddr | output | 32 | Translated physical address |
| lkDirty | output | 1 | Selected half dirty bit |
| lkAttr | output | 3 | Selected half cache attribute |

## Verification
The assertions check several properties on every cycle:
- The one-cycle completion pulse.
- That `idxO` moves only after a probe, and the staging outputs only after a read.
- That a flush request only accompanies a read result.
- That a miss keeps the low bits of the staged index.
- That a probe hit stays in range.
- That `lkValid` never appears without `lkHit`.

Only the bench's scenarios can show the following:
- Field packing on write and read.
- Lowest-entry priority among duplicate tags.
- Global versus identifier matching.
- Even/odd half selection under enlarged page sizes.
- The frame-plus-offset address arithmetic.

The bench checks these with a behavioural reference model that runs alongside the design.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W    = 32;
  localparam int ASID_W  = 8;
  localparam int TAG_LSB = 13;
  localparam int TAG_W   = VA_W - TAG_LSB;
  localparam int MASK_W  = 12;
  localparam int PFN_W   = 20;
  localparam int OFS_W   = 12;
  localparam int LO_PAD  = VA_W - 6 - PFN_W;
  localparam int HI_GAP  = TAG_LSB - ASID_W;
  localparam int PM_PAD  = VA_W - TAG_LSB - MASK_W;
  localparam int MISS_BIT = 31;

  typedef enum logic [1:0] {
    OP_WR_IDX = 2'd0,
    OP_WR_RND = 2'd1,
    OP_PROBE  = 2'd2,
    OP_READ   = 2'd3
  } opKind_t;

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic [2:0]       attr;
    logic [PFN_W-1:0] pfn;
  } half_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic [MASK_W-1:0] mask;
    logic              glob;
    half_t             even;
    half_t             odd;
  } entry_t;

  typedef struct packed {
    logic wrEn;
    logic wrRandom;
    logic probe;
    logic read;
  } ctlStrobe_t;
endpackage

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opKind,
  output ctlStrobe_t strobe,
  output logic       doneO
);
  always_comb begin
    strobe = '0;
    if (opValid) begin
      unique case (opKind_t'(opKind))
        OP_WR_IDX: strobe.wrEn = 1'b1;
        OP_WR_RND: begin
          strobe.wrEn     = 1'b1;
          strobe.wrRandom = 1'b1;
        end
        OP_PROBE:  strobe.probe = 1'b1;
        OP_READ:   strobe.read  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneO <= 1'b0;
    else       doneO <= opValid;
  end
endmodule

// File: rtl/xlt_match.sv
module xlt_match
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  entry_t [ENTRIES-1:0]         tblIn,
  input  logic [VA_W-1:0]              va,
  input  logic [ASID_W-1:0]            asid,
  output logic                         hit,
  output logic [$clog2(ENTRIES)-1:0]   hitIdx
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] hitVec;
  logic               unusedLow;
  assign unusedLow = ^va[TAG_LSB-1:0];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [TAG_W-1:0] care;
    logic             tagEq;
    logic             spaceEq;
    assign care    = ~{{(TAG_W-MASK_W){1'b0}}, tblIn[e].mask};
    assign tagEq   = ((tblIn[e].tag ^ va[VA_W-1:TAG_LSB]) & care) == '0;
    assign spaceEq = tblIn[e].glob || (tblIn[e].asid == asid);
    assign hitVec[e] = tagEq && spaceEq;
  end

  always_comb begin
    hitIdx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hitVec[e]) hitIdx = IDX_W'(e);
    end
  end

  assign hit = |hitVec;
endmodule

// File: rtl/xlt_store.sv
module xlt_store
  import xlt_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter bit LOOKUP_EN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic [VA_W-1:0]            stageHi,
  input  logic [VA_W-1:0]            stageLo0,
  input  logic [VA_W-1:0]            stageLo1,
  input  logic [VA_W-1:0]            stageMask,
  input  logic [VA_W-1:0]            stageIdx,
  input  logic [$clog2(ENTRIES)-1:0] randIdx,
  input  logic [VA_W-1:0]            lkVaddr,
  input  logic [ASID_W-1:0]          lkAsid,
  output logic [VA_W-1:0]            idxO,
  output logic [VA_W-1:0]            hiO,
  output logic [VA_W-1:0]            lo0O,
  output logic [VA_W-1:0]            lo1O,
  output logic [VA_W-1:0]            maskO,
  output logic                       flushReq,
  output logic                       lkHit,
  output logic                       lkValid,
  output logic [VA_W-1:0]            lkPaddr,
  output logic                       lkDirty,
  output logic [2:0]                 lkAttr
);
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic half_t splitHalf(input logic [VA_W-1:0] lo);
    half_t h;
    h.valid = lo[1];
    h.dirty = lo[2];
    h.attr  = lo[5:3];
    h.pfn   = lo[6 +: PFN_W];
    return h;
  endfunction

  function automatic logic [VA_W-1:0] joinHalf(input half_t h, input logic g);
    return {{LO_PAD{1'b0}}, h.pfn, h.attr, h.dirty, h.valid, g};
  endfunction

  entry_t [ENTRIES-1:0] tbl;
  entry_t               newEntry;
  entry_t               rdEnt;
  logic [IDX_W-1:0]     wrIdx;
  logic [IDX_W-1:0]     rdIdx;
  logic                 prHit;
  logic [IDX_W-1:0]     prIdx;
  logic                 unusedBits;

  assign unusedBits = ^{stageHi[TAG_LSB-1:ASID_W], stageLo0[VA_W-1:6+PFN_W],
                        stageLo1[VA_W-1:6+PFN_W], stageMask[VA_W-1:TAG_LSB+MASK_W],
                        stageMask[TAG_LSB-1:0]};

  always_comb begin
    newEntry.tag  = stageHi[VA_W-1:TAG_LSB];
    newEntry.asid = stageHi[ASID_W-1:0];
    newEntry.mask = stageMask[TAG_LSB +: MASK_W];
    newEntry.glob = stageLo0[0] & stageLo1[0];
    newEntry.even = splitHalf(stageLo0);
    newEntry.odd  = splitHalf(stageLo1);
  end

  assign wrIdx = strobe.wrRandom ? randIdx : stageIdx[IDX_W-1:0];
  assign rdIdx = stageIdx[IDX_W-1:0];
  assign rdEnt = tbl[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) tbl <= '0;
    else if (strobe.wrEn) tbl[wrIdx] <= newEntry;
  end

  xlt_match #(.ENTRIES(ENTRIES)) u_probeMatch (
    .tblIn (tbl),
    .va    (stageHi),
    .asid  (stageHi[ASID_W-1:0]),
    .hit   (prHit),
    .hitIdx(prIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxO     <= '0;
      hiO      <= '0;
      lo0O     <= '0;
      lo1O     <= '0;
      maskO    <= '0;
      flushReq <= 1'b0;
    end else begin
      flushReq <= 1'b0;
      if (strobe.probe) begin
        if (prHit) idxO <= {{(VA_W-IDX_W){1'b0}}, prIdx};
        else begin
          idxO           <= stageIdx;
          idxO[MISS_BIT] <= 1'b1;
        end
      end
      if (strobe.read) begin
        hiO      <= {rdEnt.tag, {HI_GAP{1'b0}}, rdEnt.asid};
        lo0O     <= joinHalf(rdEnt.even, rdEnt.glob);
        lo1O     <= joinHalf(rdEnt.odd, rdEnt.glob);
        maskO    <= {{PM_PAD{1'b0}}, rdEnt.mask, {TAG_LSB{1'b0}}};
        flushReq <= !rdEnt.glob && (rdEnt.asid != stageHi[ASID_W-1:0]);
      end
    end
  end

  if (LOOKUP_EN) begin : g_look
    logic             lmHit;
    logic [IDX_W-1:0] lmIdx;
    entry_t           lmEnt;
    half_t            lmHalf;
    logic [VA_W-1:0]  offMask;
    logic [VA_W-1:0]  selBit;
    logic [VA_W-1:0]  frame;

    xlt_match #(.ENTRIES(ENTRIES)) u_lookMatch (
      .tblIn (tbl),
      .va    (lkVaddr),
      .asid  (lkAsid),
      .hit   (lmHit),
      .hitIdx(lmIdx)
    );

    always_comb begin
      lmEnt   = tbl[lmIdx];
      offMask = {{(VA_W-MASK_W-OFS_W){1'b0}}, lmEnt.mask, {OFS_W{1'b1}}};
      selBit  = (offMask + 32'd1) & ~offMask;
      lmHalf  = ((lkVaddr & selBit) != '0) ? lmEnt.odd : lmEnt.even;
      frame   = {lmHalf.pfn, {OFS_W{1'b0}}};
      lkHit   = lmHit;
      lkValid = lmHit && lmHalf.valid;
      lkDirty = lmHit && lmHalf.dirty;
      lkAttr  = lmHit ? lmHalf.attr : 3'd0;
      lkPaddr = lmHit ? ((frame & ~offMask) | (lkVaddr & offMask)) : '0;
    end
  end else begin : g_noLook
    logic unusedLook;
    assign unusedLook = ^{lkVaddr, lkAsid};
    assign lkHit   = 1'b0;
    assign lkValid = 1'b0;
    assign lkDirty = 1'b0;
    assign lkAttr  = 3'd0;
    assign lkPaddr = '0;
  end
endmodule

// File: rtl/xlt_unit.sv
module xlt_unit
  import xlt_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter bit LOOKUP_EN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       opValid,
  input  logic [1:0]                 opKind,
  input  logic [31:0]                stageHi,
  input  logic [31:0]                stageLo0,
  input  logic [31:0]                stageLo1,
  input  logic [31:0]                stageMask,
  input  logic [31:0]                stageIdx,
  input  logic [$clog2(ENTRIES)-1:0] randIdx,
  input  logic [31:0]                lkVaddr,
  input  logic [7:0]                 lkAsid,
  output logic                       doneO,
  output logic [31:0]                idxO,
  output logic [31:0]                hiO,
  output logic [31:0]                lo0O,
  output logic [31:0]                lo1O,
  output logic [31:0]                maskO,
  output logic                       flushReq,
  output logic                       lkHit,
  output logic                       lkValid,
  output logic [31:0]                lkPaddr,
  output logic                       lkDirty,
  output logic [2:0]                 lkAttr
);
  ctlStrobe_t strobe;

  xlt_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opKind (opKind),
    .strobe (strobe),
    .doneO  (doneO)
  );

  xlt_store #(.ENTRIES(ENTRIES), .LOOKUP_EN(LOOKUP_EN)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .stageHi  (stageHi),
    .stageLo0 (stageLo0),
    .stageLo1 (stageLo1),
    .stageMask(stageMask),
    .stageIdx (stageIdx),
    .randIdx  (randIdx),
    .lkVaddr  (lkVaddr),
    .lkAsid   (lkAsid),
    .idxO     (idxO),
    .hiO      (hiO),
    .lo0O     (lo0O),
    .lo1O     (lo1O),
    .maskO    (maskO),
    .flushReq (flushReq),
    .lkHit    (lkHit),
    .lkValid  (lkValid),
    .lkPaddr  (lkPaddr),
    .lkDirty  (lkDirty),
    .lkAttr   (lkAttr)
  );
endmodule

// File: rtl/xlt_unit_chk.sv
module xlt_unit_chk #(
  parameter int ENTRIES = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [1:0]  opKind,
  input logic [31:0] stageIdx,
  input logic        doneO,
  input logic [31:0] idxO,
  input logic [31:0] hiO,
  input logic [31:0] lo0O,
  input logic [31:0] lo1O,
  input logic [31:0] maskO,
  input logic        flushReq,
  input logic        lkHit,
  input logic        lkValid
);
  AST_DONE_AFTER_OP: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> doneO);                                                       // R2
  AST_DONE_NEEDS_OP: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> $past(opValid));                                                // R2
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && $past(opKind) == 2'd2 && !idxO[31]) |-> (idxO < 32'(ENTRIES))); // R4
  AST_MISS_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && $past(opKind) == 2'd2 && idxO[31]) |-> (idxO[30:0] == $past(stageIdx[30:0]))); // R6
  AST_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (doneO && $past(opKind) == 2'd3));                           // R8
  AST_VALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> lkHit);                                                       // R9
  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(doneO && $past(opKind) == 2'd2) |-> $stable(idxO));                     // R11
  AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(doneO && $past(opKind) == 2'd3) |->
      ($stable(hiO) && $stable(lo0O) && $stable(lo1O) && $stable(maskO)));    // R11
endmodule

bind xlt_unit xlt_unit_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opKind  (opKind),
  .stageIdx(stageIdx),
  .doneO   (doneO),
  .idxO    (idxO),
  .hiO     (hiO),
  .lo0O    (lo0O),
  .lo1O    (lo1O),
  .maskO   (maskO),
  .flushReq(flushReq),
  .lkHit   (lkHit),
  .lkValid (lkValid)
);

// File: tb/xlt_unit_bench.sv
module xlt_unit_bench;
  localparam int ENTRIES = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        opValid;
  logic [1:0]  opKind;
  logic [31:0] stageHi, stageLo0, stageLo1, stageMask, stageIdx;
  logic [3:0]  randIdx;
  logic [31:0] lkVaddr;
  logic [7:0]  lkAsid;
  logic        doneO, flushReq, lkHit, lkValid, lkDirty;
  logic [31:0] idxO, hiO, lo0O, lo1O, maskO, lkPaddr;
  logic [2:0]  lkAttr;

  xlt_unit #(.ENTRIES(ENTRIES)) u_xlt_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .stageHi(stageHi), .stageLo0(stageLo0), .stageLo1(stageLo1),
    .stageMask(stageMask), .stageIdx(stageIdx), .randIdx(randIdx),
    .lkVaddr(lkVaddr), .lkAsid(lkAsid), .doneO(doneO), .idxO(idxO),
    .hiO(hiO), .lo0O(lo0O), .lo1O(lo1O), .maskO(maskO), .flushReq(flushReq),
    .lkHit(lkHit), .lkValid(lkValid), .lkPaddr(lkPaddr), .lkDirty(lkDirty),
    .lkAttr(lkAttr)
  );

  int tests = 0;
  int fails = 0;

  // behavioural reference state
  logic [31:0] mTag[ENTRIES], mAsid[ENTRIES], mPm[ENTRIES], mG[ENTRIES];
  logic [31:0] mLoE[ENTRIES], mLoO[ENTRIES];
  logic        eDone, eFlush;
  logic [31:0] eIdx, eHi, eLo0, eLo1, eMask;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int mFind(input logic [31:0] va, input logic [7:0] as);
    for (int i = 0; i < ENTRIES; i++) begin
      if ((((mTag[i] ^ va) & 32'hFFFFE000 & ~mPm[i]) == 32'd0) &&
          (mG[i] != 0 || mAsid[i] == {24'd0, as}))
        return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        mTag[i] = 0; mAsid[i] = 0; mPm[i] = 0; mG[i] = 0; mLoE[i] = 0; mLoO[i] = 0;
      end
      eDone = 0; eFlush = 0; eIdx = 0; eHi = 0; eLo0 = 0; eLo1 = 0; eMask = 0;
    end else begin
      eDone  = opValid;
      eFlush = 0;
      if (opValid) begin
        if (opKind == 2'd0 || opKind == 2'd1) begin
          int w;
          w = (opKind == 2'd0) ? int'(stageIdx % ENTRIES) : int'(randIdx);
          mTag[w]  = stageHi & 32'hFFFFE000;
          mAsid[w] = stageHi & 32'h000000FF;
          mPm[w]   = stageMask & 32'h01FFE000;
          mG[w]    = {31'd0, stageLo0[0] & stageLo1[0]};
          mLoE[w]  = stageLo0 & 32'h03FFFFFE;
          mLoO[w]  = stageLo1 & 32'h03FFFFFE;
        end else if (opKind == 2'd2) begin
          int f;
          f = mFind(stageHi, stageHi[7:0]);
          eIdx = (f < 0) ? (stageIdx | 32'h80000000) : f;
        end else begin
          int r;
          r = int'(stageIdx % ENTRIES);
          eHi    = mTag[r] | mAsid[r];
          eLo0   = mLoE[r] | mG[r];
          eLo1   = mLoO[r] | mG[r];
          eMask  = mPm[r];
          eFlush = (mG[r] == 0) && (mAsid[r] != {24'd0, stageHi[7:0]});
        end
      end
    end
  end

  // per-cycle comparison against the reference model
  always @(negedge clk) begin : cmpBlk
    int f;
    logic [31:0] pg, lo, pa;
    if (rstN) begin
      chkEq("R2 done pulse", {31'd0, doneO}, {31'd0, eDone});
      chkEq("R4 index result", idxO, eIdx);
      chkEq("R7 hi readback", hiO, eHi);
      chkEq("R7 lo0 readback", lo0O, eLo0);
      chkEq("R7 lo1 readback", lo1O, eLo1);
      chkEq("R10 mask readback", maskO, eMask);
      chkEq("R8 flush", {31'd0, flushReq}, {31'd0, eFlush});
      f = mFind(lkVaddr, lkAsid);
      if (f < 0) begin
        chkEq("R9 lookup miss", {lkHit, lkValid, lkDirty, lkAttr, lkPaddr}, 32'd0);
      end else begin
        pg = 32'h1000 << $countones(mPm[f]);
        lo = ((lkVaddr & pg) != 0) ? mLoO[f] : mLoE[f];
        pa = (((lo >> 6) << 12) & ~(pg - 1)) | (lkVaddr & (pg - 1));
        chkEq("R9 lookup hit", {31'd0, lkHit}, 32'd1);
        chkEq("R10 lookup paddr", lkPaddr, pa);
        chkEq("R9 lookup flags", {27'd0, lkValid, lkDirty, lkAttr},
              {27'd0, lo[1], lo[2], lo[5:3]});
      end
    end
  end

  task automatic doOp(input logic [1:0] k, input logic [31:0] hi, input logic [31:0] l0,
                      input logic [31:0] l1, input logic [31:0] pm, input logic [31:0] ix,
                      input logic [3:0] rnd);
    @(posedge clk); #2;
    opValid = 1'b1; opKind = k; stageHi = hi; stageLo0 = l0; stageLo1 = l1;
    stageMask = pm; stageIdx = ix; randIdx = rnd;
    @(posedge clk); #2;
    opValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] as);
    @(posedge clk); #2;
    lkVaddr = va; lkAsid = as;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R2 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opKind = 2'd0; stageHi = 0; stageLo0 = 0; stageLo1 = 0;
    stageMask = 0; stageIdx = 0; randIdx = 0; lkVaddr = 0; lkAsid = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 idx reset", idxO, 32'd0);
    chkEq("R1 hi reset", hiO, 32'd0);
    chkEq("R1 lo reset", lo0O | lo1O | maskO, 32'd0);
    chkEq("R1 flags reset", {30'd0, doneO, flushReq}, 32'd0);
    chkEq("R1 lookup invalid", {31'd0, lkValid}, 32'd0);

    // R3 indexed write modulo count, R7 read back
    doOp(2'd0, 32'h12346021, 32'h02AF379F, 32'h00444452, 32'd0, 32'h13, 4'd0);
    doOp(2'd3, 32'h12346021, 32'd0, 32'd0, 32'd0, 32'd3, 4'd0);
    chkEq("R7 hi", hiO, 32'h12346021);
    chkEq("R3 global is AND", lo0O, 32'h02AF379E);
    chkEq("R7 lo1", lo1O, 32'h00444452);
    chkEq("R8 same space no flush", {31'd0, flushReq}, 32'd0);
    chkEq("R11 idx untouched by read", idxO, 32'd0);

    // R9 lookup even/odd halves and space mismatch
    look(32'h12346ABC, 8'h21);
    chkEq("R9 even paddr", lkPaddr, 32'hABCDEABC);
    chkEq("R9 even flags", {28'd0, lkDirty, lkAttr}, {28'd0, 1'b1, 3'd3});
    look(32'h12347ABC, 8'h21);
    chkEq("R9 odd paddr", lkPaddr, 32'h11111ABC);
    look(32'h12346ABC, 8'h22);
    chkEq("R9 other space misses", {31'd0, lkHit}, 32'd0);

    // R3 random write, R4 global probe hit
    doOp(2'd1, 32'h400020FF, 32'd3, 32'd1, 32'd0, 32'd0, 4'd9);
    doOp(2'd2, 32'h40002005, 32'd0, 32'd0, 32'd0, 32'd0, 4'd0);
    chkEq("R4 probe global hit", idxO, 32'd9);
    chkEq("R11 hi untouched by probe", hiO, 32'h12346021);

    // R6 probe miss
    doOp(2'd2, 32'h7777E000, 32'd0, 32'd0, 32'd0, 32'd5, 4'd0);
    chkEq("R6 probe miss", idxO, 32'h80000005);

    // R5 duplicate tags, lowest wins
    doOp(2'd0, 32'h00C02033, 32'd2, 32'd2, 32'd0, 32'd11, 4'd0);
    doOp(2'd0, 32'h00C02033, 32'd2, 32'd2, 32'd0, 32'd6, 4'd0);
    doOp(2'd2, 32'h00C02033, 32'd0, 32'd0, 32'd0, 32'd0, 4'd0);
    chkEq("R5 lowest match", idxO, 32'd6);

    // R8 flush on space change only for non-global
    doOp(2'd3, 32'h00000044, 32'd0, 32'd0, 32'd0, 32'd3, 4'd0);
    chkEq("R8 flush raised", {31'd0, flushReq}, 32'd1);
    chkEq("R7 hi keeps entry space", hiO, 32'h12346021);
    @(negedge clk);
    chkEq("R8 flush one cycle", {31'd0, flushReq}, 32'd0);
    doOp(2'd3, 32'h00000044, 32'd0, 32'd0, 32'd0, 32'd9, 4'd0);
    chkEq("R8 global no flush", {31'd0, flushReq}, 32'd0);
    chkEq("R7 global lo0", lo0O, 32'd3);

    // R9 invalid half still hits
    doOp(2'd0, 32'h0ABC0011, 32'h42, 32'h40, 32'd0, 32'd5, 4'd0);
    look(32'h0ABC1000, 8'h11);
    chkEq("R9 invalid hit", {30'd0, lkHit, lkValid}, 32'd2);

    // R10 enlarged page
    doOp(2'd0, 32'h80000007, 32'h4002, 32'h8002, 32'h6000, 32'd12, 4'd0);
    look(32'h80003456, 8'h07);
    chkEq("R10 big page even", lkPaddr, 32'h00103456);
    look(32'h80007456, 8'h07);
    chkEq("R10 big page odd", lkPaddr, 32'h00203456);
    doOp(2'd2, 32'h80006007, 32'd0, 32'd0, 32'd0, 32'd0, 4'd0);
    chkEq("R10 masked probe", idxO, 32'd12);
    doOp(2'd3, 32'h80000007, 32'd0, 32'd0, 32'd0, 32'd12, 4'd0);
    chkEq("R10 mask readback", maskO, 32'h00006000);

    // mixed traffic, checked every cycle by the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] vpn, hi, pm;
      logic [7:0]  as;
      case ($urandom % 4)
        0: vpn = 32'h12346000;
        1: vpn = 32'h80000000;
        2: vpn = 32'h00C02000;
        default: vpn = 32'h40002000;
      endcase
      case ($urandom % 4)
        0: as = 8'h21;
        1: as = 8'h33;
        2: as = 8'h07;
        default: as = 8'h05;
      endcase
      case ($urandom % 3)
        0: pm = 32'd0;
        1: pm = 32'h2000;
        default: pm = 32'h6000;
      endcase
      hi = vpn | ($urandom & 32'h00007F00) | {24'd0, as};
      doOp(2'($urandom), hi, $urandom, $urandom, pm, $urandom, 4'($urandom));
      look(vpn | ($urandom & 32'h0000FFFF), as);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule